// File: doc/BRIEF.md
# AES Key Slot Table Loader

This block holds the key and IV material for an AES engine in eight slot register sets. Software writes a 64-byte table into a small staging RAM one 32-bit word at a time. It then issues a table-load command that copies the whole table into one slot. A table holds up to 256 bits of key, followed by the starting IV and then the running (updated) IV. The key schedule and the cipher core sit outside the block. The block only stores the material and reports the programmed key length.

A configuration port picks the slot that the cipher side reads and sets the key length in bits. One slot is reserved as a secure slot, filled by other means. A table-load command must never overwrite it. The load copies one word per clock. Key words beyond the programmed key length are stored as zero, so a short key never carries stale bytes into the slot.

Top module: `keyslot_loader`

## Requirements
- R1: After reset, `busy`, `load_denied` and `len_err` are 0, `key_bits` is 128, the active slot is 0 and every word of every slot reads as zero.
- R2: A command is a table load only if all of these fields match: bits [31:26] = 0x15, bits [25:24] = 3, bit 23 = 1, and the table ID in bits [22:17] equals 0x8 OR the slot number. That means bits [22:20] = 3'b001 and the slot number is in bits [19:17]. Bits [16:0] are ignored.
- R3: A command whose fields do not all match has no effect: `busy` stays 0 and no slot changes.
- R4: An accepted load raises `busy` on the clock edge that samples the command. `busy` then stays high for exactly 16 cycles. Word k is written on the (k+1)-th edge after acceptance, and `busy` falls on the edge that writes word 15.
- R5: Staging words 0–7 are the key (word 0 first), words 8–11 the original IV, and words 12–15 the updated IV. A load copies each staging word to the same word index of the target slot.
- R6: During a load, key words with index at or above `key_bits`/32 are written as zero. The key length used is the one in effect when the command is accepted.
- R7: A load aimed at the secure slot (slot 4 by default) leaves every slot unchanged and keeps `busy` at 0. It raises `load_denied` for exactly one cycle after the accepting edge.
- R8: A configuration write of 128, 192 or 256 sets `key_bits` on the next edge. Any other value keeps the previous `key_bits` and pulses `len_err` for one cycle. The slot field is taken in both cases.
- R9: `rd_data` shows, in the same cycle, word `rd_idx` of the slot chosen by the last configuration write.
- R10: A command presented while `busy` is high is dropped, including one aimed at the secure slot, which then raises no `load_denied`.
- R11: A load changes only its target slot. All other slots keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_we | input | 1 | Staging RAM write strobe |
| stg_addr | input | 4 | Staging RAM word index |
| stg_wdata | input | 32 | Staging RAM write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Command word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Active slot index to program |
| cfg_kbits | input | 9 | Key length in bits to program |
| rd_idx | input | 4 | Word index for the read port |
| rd_data | output | 32 | Word of the active slot |
| key_bits | output | 9 | Programmed key length in bits |
| busy | output | 1 | Table copy in progress |
| load_denied | output | 1 | One-cycle pulse: load to secure slot refused |
| len_err | output | 1 | One-cycle pulse: illegal key length refused |

## Verification
The command is sampled on an edge, and the block answers on that same edge. `busy` and `load_denied` are due one cycle after the command, and `busy` is due low seventeen cycles after it. `key_bits` and `len_err` follow a configuration write by one cycle, and `len_err` must be back to 0 one cycle after that. `rd_data` is combinational, so it is due in the same cycle as `rd_idx`. The driver records the cycle number at which it presents each stimulus. It queues each timed output with its due cycle, and a monitor samples two nanoseconds after every edge and compares only the entries due in that cycle. Slot contents are read back through the read port only after the copy has finished.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  localparam int WORD_W        = 32;
  localparam int TABLE_WORDS   = 16;
  localparam int KEY_WORDS_MAX = 8;
  localparam int SLOT_W        = 3;
  localparam int KBITS_W       = 9;
  localparam int IDX_W         = $clog2(TABLE_WORDS);

  localparam logic [5:0] OPC_TABLE_LOAD = 6'h15;
  localparam logic [1:0] TSEL_CRYPTO    = 2'd3;
  localparam logic [2:0] TBLID_KEY_HI   = 3'b001;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } load_req_t;

  function automatic logic kbits_legal(input logic [KBITS_W-1:0] b);
    return (b == 9'd128) || (b == 9'd192) || (b == 9'd256);
  endfunction

  function automatic logic [IDX_W-1:0] kbits_words(input logic [KBITS_W-1:0] b);
    return IDX_W'(b >> 5);
  endfunction
endpackage

// File: rtl/ks_cmd_decode.sv
module ks_cmd_decode
  import keyslot_pkg::*;
(
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  output load_req_t   req
);
  logic op_ok, tsel_ok, ram_ok, id_ok;

  always_comb begin
    op_ok    = (cmd_word[31:26] == OPC_TABLE_LOAD);
    tsel_ok  = (cmd_word[25:24] == TSEL_CRYPTO);
    ram_ok   = cmd_word[23];
    id_ok    = (cmd_word[22:20] == TBLID_KEY_HI);
    req.hit  = cmd_valid && op_ok && tsel_ok && ram_ok && id_ok;
    req.slot = cmd_word[19:17];
  end
endmodule

// File: rtl/ks_stage_ram.sv
module ks_stage_ram
  import keyslot_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int DEPTH = TABLE_WORDS,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ks_copy_seq.sv
module ks_copy_seq
  import keyslot_pkg::*;
#(
  parameter int DEPTH       = TABLE_WORDS,
  parameter int SECURE_SLOT = 4,
  localparam int AW         = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  load_req_t         req,
  input  logic [AW-1:0]     key_words,
  output logic              busy,
  output logic              denied,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [AW-1:0]     wr_idx,
  output logic              wr_zero
);
  localparam logic [AW-1:0]     LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW-1:0]     KEY_END  = AW'(KEY_WORDS_MAX);
  localparam logic [SLOT_W-1:0] SEC_ID   = SLOT_W'(SECURE_SLOT);

  logic              busy_q, busy_d;
  logic              deny_q, deny_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [AW-1:0]     kw_q, kw_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              accept, refuse;

  always_comb begin
    accept = req.hit && !busy_q && (req.slot != SEC_ID);
    refuse = req.hit && !busy_q && (req.slot == SEC_ID);
    busy_d = busy_q;
    idx_d  = idx_q;
    kw_d   = kw_q;
    slot_d = slot_q;
    deny_d = refuse;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      kw_d   = key_words;
      slot_d = req.slot;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      deny_q <= 1'b0;
      idx_q  <= '0;
      kw_q   <= '0;
      slot_q <= '0;
    end else begin
      busy_q <= busy_d;
      deny_q <= deny_d;
      idx_q  <= idx_d;
      kw_q   <= kw_d;
      slot_q <= slot_d;
    end
  end

  assign busy    = busy_q;
  assign denied  = deny_q;
  assign wr_en   = busy_q;
  assign wr_slot = slot_q;
  assign wr_idx  = idx_q;
  assign wr_zero = (idx_q < KEY_END) && (idx_q >= kw_q);
endmodule

// File: rtl/ks_slot_bank.sv
module ks_slot_bank
  import keyslot_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int DEPTH = TABLE_WORDS,
  localparam int AW   = $clog2(DEPTH),
  localparam int NS   = 1 << SLOT_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [AW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [AW-1:0]     rd_idx,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] mem [NS][DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < DEPTH; w++)
          mem[s][w] <= '0;
    end else if (wr_en) begin
      mem[wr_slot][wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_slot][rd_idx];
endmodule

// File: rtl/ks_cfg_reg.sv
module ks_cfg_reg
  import keyslot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SLOT_W-1:0]  slot_in,
  input  logic [KBITS_W-1:0] kbits_in,
  output logic [SLOT_W-1:0]  active_slot,
  output logic [KBITS_W-1:0] kbits,
  output logic               len_err
);
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [KBITS_W-1:0] kb_q, kb_d;
  logic               err_q, err_d;

  always_comb begin
    slot_d = slot_q;
    kb_d   = kb_q;
    err_d  = 1'b0;
    if (we) begin
      slot_d = slot_in;
      if (kbits_legal(kbits_in)) kb_d = kbits_in;
      else                        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      kb_q   <= KBITS_W'(128);
      err_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      kb_q   <= kb_d;
      err_q  <= err_d;
    end
  end

  assign active_slot = slot_q;
  assign kbits       = kb_q;
  assign len_err     = err_q;
endmodule

// File: rtl/keyslot_loader.sv
module keyslot_loader
  import keyslot_pkg::*;
#(
  parameter int W           = WORD_W,
  parameter int SECURE_SLOT = 4,
  localparam int AW         = $clog2(TABLE_WORDS)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stg_we,
  input  logic [AW-1:0]      stg_addr,
  input  logic [W-1:0]       stg_wdata,
  input  logic               cmd_valid,
  input  logic [31:0]        cmd_word,
  input  logic               cfg_we,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [KBITS_W-1:0] cfg_kbits,
  input  logic [AW-1:0]      rd_idx,
  output logic [W-1:0]       rd_data,
  output logic [KBITS_W-1:0] key_bits,
  output logic               busy,
  output logic               load_denied,
  output logic               len_err
);
  load_req_t         req;
  logic [SLOT_W-1:0] act_slot;
  logic              wr_en, wr_zero;
  logic [SLOT_W-1:0] wr_slot;
  logic [AW-1:0]     wr_idx;
  logic [W-1:0]      stg_rdata, wr_data;

  ks_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .req       (req)
  );

  ks_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .slot_in     (cfg_slot),
    .kbits_in    (cfg_kbits),
    .active_slot (act_slot),
    .kbits       (key_bits),
    .len_err     (len_err)
  );

  ks_stage_ram #(.W(W), .DEPTH(TABLE_WORDS)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (stg_we),
    .waddr (stg_addr),
    .wdata (stg_wdata),
    .raddr (wr_idx),
    .rdata (stg_rdata)
  );

  ks_copy_seq #(.DEPTH(TABLE_WORDS), .SECURE_SLOT(SECURE_SLOT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .key_words (kbits_words(key_bits)),
    .busy      (busy),
    .denied    (load_denied),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .wr_idx    (wr_idx),
    .wr_zero   (wr_zero)
  );

  assign wr_data = wr_zero ? '0 : stg_rdata;

  ks_slot_bank #(.W(W), .DEPTH(TABLE_WORDS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_slot (act_slot),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/keyslot_loader_chk.sv
module keyslot_loader_chk
  import keyslot_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cfg_we,
  input logic [KBITS_W-1:0] key_bits,
  input logic               busy,
  input logic               load_denied,
  input logic               len_err
);
  localparam int CW = $clog2(TABLE_WORDS) + 2;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < CW'(TABLE_WORDS)));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CW'(TABLE_WORDS)));

  assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_deny_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_denied |-> (!busy && $past(cmd_valid) && !$past(busy)));

  assert_len_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> ((key_bits == $past(key_bits)) && $past(cfg_we)));

  assert_len_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kbits_legal(key_bits));
endmodule

bind keyslot_loader keyslot_loader_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cfg_we      (cfg_we),
  .key_bits    (key_bits),
  .busy        (busy),
  .load_denied (load_denied),
  .len_err     (len_err)
);

// File: tb/test_keyslot_loader.sv
module test_keyslot_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stg_we;
  logic [3:0]  stg_addr;
  logic [31:0] stg_wdata;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic        cfg_we;
  logic [2:0]  cfg_slot;
  logic [8:0]  cfg_kbits;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic [8:0]  key_bits;
  logic        busy, load_denied, len_err;

  keyslot_loader i_keyslot_loader (
    .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_wdata(stg_wdata), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_kbits(cfg_kbits),
    .rd_idx(rd_idx), .rd_data(rd_data), .key_bits(key_bits), .busy(busy),
    .load_denied(load_denied), .len_err(len_err)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0;
  int          bad   = 0;
  int          cyc   = 0;
  logic [31:0] stage_m [16];
  logic [31:0] slot_m  [8][16];
  int          bits_m  = 128;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sig_val(int s);
    case (s)
      0:       return int'(busy);
      1:       return int'(load_denied);
      2:       return int'(len_err);
      default: return int'(key_bits);
    endcase
  endfunction

  function automatic void expect_at(int c, int s, int v, string tag);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endfunction

  // scoreboard monitor: samples 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          check(q[i].tag, sig_val(q[i].sig), q[i].val);
          q.delete(i);
        end
      end
    end
  end

  function automatic logic [31:0] mk_cmd(logic [5:0] op, logic [1:0] ts,
                                         logic rs, logic [5:0] id);
    return {op, ts, rs, id, 17'h0A5A5};
  endfunction

  task automatic cfg_write(int slot, int kb, string tag);
    int c0;
    @(negedge clk);
    c0 = cyc;
    cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_kbits = 9'(kb);
    if (kb == 128 || kb == 192 || kb == 256) bits_m = kb;
    expect_at(c0 + 1, 3, bits_m, tag);
    expect_at(c0 + 1, 2, (kb == 128 || kb == 192 || kb == 256) ? 0 : 1, tag);
    expect_at(c0 + 2, 2, 0, tag);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic stage_fill(logic [31:0] seed);
    for (int w = 0; w < 16; w++) begin
      @(negedge clk);
      stg_we = 1'b1; stg_addr = 4'(w);
      stg_wdata = seed ^ (32'h0101_0101 * (w + 1));
      stage_m[w] = stg_wdata;
    end
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  // issue a command, queue timed expectations, update model, wait for copy
  task automatic issue(logic [31:0] cw, string tag);
    int  c0;
    bit  hit, acc;
    int  s;
    hit = (cw[31:26] == 6'h15) && (cw[25:24] == 2'd3) && cw[23] && (cw[22:20] == 3'b001);
    s   = int'(cw[19:17]);
    acc = hit && (s != 4);
    @(negedge clk);
    c0 = cyc;
    cmd_valid = 1'b1; cmd_word = cw;
    expect_at(c0 + 1, 1, (hit && s == 4) ? 1 : 0, tag);
    if (acc) begin
      for (int k = 1; k <= 16; k++) expect_at(c0 + k, 0, 1, tag);
      expect_at(c0 + 17, 0, 0, tag);
      for (int w = 0; w < 16; w++)
        slot_m[s][w] = (w < 8 && w >= bits_m / 32) ? 32'h0 : stage_m[w];
    end else begin
      expect_at(c0 + 1, 0, 0, tag);
      expect_at(c0 + 2, 1, 0, tag);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (18) @(negedge clk);
  endtask

  task automatic verify_slot(int s, string tag);
    cfg_write(s, bits_m, tag);
    for (int w = 0; w < 16; w++) begin
      rd_idx = 4'(w);
      #1;
      check($sformatf("%s slot%0d word%0d", tag, s, w), int'(rd_data), int'(slot_m[s][w]));
    end
  endtask

  function automatic logic [31:0] load_cmd(int s);
    return mk_cmd(6'h15, 2'd3, 1'b1, 6'(8 | s));
  endfunction

  // watchdog
  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 16; w++) slot_m[s][w] = 32'h0;
    rst_n = 1'b0; stg_we = 1'b0; stg_addr = '0; stg_wdata = '0;
    cmd_valid = 1'b0; cmd_word = '0; cfg_we = 1'b0; cfg_slot = '0;
    cfg_kbits = 9'd128; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 load_denied", int'(load_denied), 0);
    check("R1 len_err", int'(len_err), 0);
    check("R1 key_bits", int'(key_bits), 128);
    rd_idx = 4'd9; #1;
    check("R1 R9 active slot0 reads zero", int'(rd_data), 0);
    verify_slot(0, "R1");

    // R2 R4 R5: full 256-bit key into slot 1
    cfg_write(0, 256, "R8 legal 256");
    stage_fill(32'hA5C3_0000);
    issue(load_cmd(1), "R2 R4 load slot1");
    verify_slot(1, "R5");

    // R6: 128-bit key zero-fills key words 4..7
    cfg_write(0, 128, "R8 legal 128");
    stage_fill(32'h3C1E_7700);
    issue(load_cmd(2), "R4 load slot2");
    verify_slot(2, "R6 128");
    verify_slot(1, "R11 slot1 kept");

    // R6: 192-bit key zero-fills words 6..7
    cfg_write(0, 192, "R8 legal 192");
    issue(load_cmd(7), "R4 load slot7");
    verify_slot(7, "R6 192");

    // R8: illegal lengths keep 192
    cfg_write(3, 100, "R8 illegal 100");
    cfg_write(3, 320, "R8 illegal 320");
    check("R8 key_bits kept", int'(key_bits), 192);

    // R7: secure slot refused
    issue(load_cmd(4), "R7 secure slot");
    verify_slot(4, "R7 secure untouched");

    // R3: malformed commands aimed at slot 3
    issue(mk_cmd(6'h16, 2'd3, 1'b1, 6'h0B), "R3 bad opcode");
    issue(mk_cmd(6'h15, 2'd2, 1'b1, 6'h0B), "R3 bad table select");
    issue(mk_cmd(6'h15, 2'd3, 1'b0, 6'h0B), "R3 ram bit clear");
    issue(mk_cmd(6'h15, 2'd3, 1'b1, 6'h03), "R3 id flag clear");
    issue(mk_cmd(6'h15, 2'd3, 1'b1, 6'h1B), "R3 id high bits set");
    verify_slot(3, "R3 slot3 untouched");

    // R10: commands during busy are dropped
    stage_fill(32'h0F0F_1234);
    @(negedge clk);
    c0 = cyc;
    cmd_valid = 1'b1; cmd_word = load_cmd(5);
    for (int k = 1; k <= 16; k++) expect_at(c0 + k, 0, 1, "R10 load slot5");
    expect_at(c0 + 17, 0, 0, "R10 busy ends");
    for (int w = 0; w < 16; w++)
      slot_m[5][w] = (w < 8 && w >= bits_m / 32) ? 32'h0 : stage_m[w];
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1; cmd_word = load_cmd(6);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = load_cmd(4);
    expect_at(c0 + 5, 1, 0, "R10 secure during busy no deny");
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (18) @(negedge clk);
    verify_slot(6, "R10 slot6 untouched");
    verify_slot(5, "R10 slot5 loaded");
    verify_slot(2, "R11 slot2 kept");

    repeat (3) @(negedge clk);
    check("scoreboard drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule